// File: doc/BRIEF.md
# Indexed Register Front End for an Interrupt Router

This block is the software-visible register file of a 32-pin interrupt routing controller. Software sees only two 32-bit locations. The first is an index register. The second is a data window. A write to the index register chooses a target. Accesses to the window then read or write that target. The targets are an identifier register, a version register, an arbitration register and one 64-bit routing entry per pin. Each routing entry is reached as two separate 32-bit halves.

The block holds the routing entries and applies the write rules to them. Inside each entry there are two status flags: a remote-pending flag and a delivery-busy flag. Only the delivery logic owns them, and it updates them through a dedicated status port. Software writes never change them. The delivery logic can read any complete entry through a side read port. After every software write to an entry, the block emits a one-cycle notice that carries the pin number, so the delivery logic can re-evaluate that pin.

Top module: `irq_route_regs`

## Requirements
- R1: An access is honoured only when `bus_size` is 2 (four bytes) and `bus_addr` is 0x00 (index) or 0x10 (window). Any other access reads back zero and changes no state.
- R2: A write to the index register stores all 32 bits, and a read of offset 0x00 returns them. Only bits 7:0 choose the target. A target index outside 0x00–0x02 and 0x10–0x4F reads zero through the window, and window writes to it are dropped.
- R3: Target 0x00 is the identifier. A window write keeps only data bits 31:24 and clears bits 23:0. Target 0x02 reads the same value as target 0x00, and window writes to target 0x02 change nothing.
- R4: Target 0x01 always reads 0x001F0011, which is the entry count minus one in bits 23:16 OR'd with 0x11. Writes to it change nothing.
- R5: Target 0x10+2p reaches bits 31:0 of the entry for pin p. Target 0x11+2p reaches bits 63:32 of the same entry.
- R6: A window write to one half replaces only that half of the entry and leaves the other half as it was.
- R7: Bit 12 (delivery-busy) and bit 14 (remote-pending) of an entry ignore software writes. They change only when `sts_we` is high, and they then take `sts_dlvs` and `sts_rirr` for pin `sts_pin`.
- R8: After reset every entry reads 0x0001_0000_0001_0000, which has bit 16 (mask) set. The index register and the identifier are zero, and all outputs are zero.
- R9: `bus_rvalid` is high in the cycle after each read request, honoured or not. `bus_rdata` holds the read value in that cycle and is zero in every other cycle.
- R10: In the cycle after an honoured window write to an entry half, `upd_valid` is 1 and `upd_pin` holds that pin. In every other cycle both are 0.
- R11: `dlv_entry` shows the full 64-bit entry of `dlv_pin`, status flags included, one cycle after `dlv_pin` is presented. The value is the entry as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| sts_we | input | 1 | Status flag update strobe from delivery logic |
| sts_pin | input | 5 | Pin whose status flags are updated |
| sts_rirr | input | 1 | New remote-pending flag value |
| sts_dlvs | input | 1 | New delivery-busy flag value |
| dlv_pin | input | 5 | Pin whose entry the delivery logic reads |
| dlv_entry | output | 64 | Registered entry of `dlv_pin` |
| upd_valid | output | 1 | Entry-written notice |
| upd_pin | output | 5 | Pin of the written entry |

## Verification
Suppose the index register or an entry held a wrong value. Nothing would show until software read it back through the window, or until the pin was selected on `dlv_pin`. At that point the error appears one cycle after the request. For this reason the bench keeps `dlv_pin` moving every cycle and mixes in frequent window reads, so that corrupted storage surfaces within a few cycles of the fault rather than at the end of the run. A status flag clobbered by software, or a write that lands in the wrong half, shows up on the next read of that entry. A missing or misdirected update notice shows on `upd_valid`/`upd_pin` in the very next cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int BUS_W = 32;
  localparam int ENT_W = 64;

  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [7:0] OFF_SEL   = 8'h00;
  localparam logic [7:0] OFF_WIN   = 8'h10;

  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;

  localparam int B_DLVS      = 12;
  localparam int B_RIRR      = 14;
  localparam int ID_LSB      = 24;
  localparam int VER_MAX_LSB = 16;
  localparam logic [7:0] VER_CODE = 8'h11;

  localparam logic [ENT_W-1:0] ENT_RESET = 64'h0001_0000_0001_0000;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_ENT
  } tgt_e;

  function automatic logic [ENT_W-1:0] merge_status(
    input logic [ENT_W-1:0] raw,
    input logic             rirr,
    input logic             dlvs
  );
    logic [ENT_W-1:0] m;
    m         = raw;
    m[B_RIRR] = rirr;
    m[B_DLVS] = dlvs;
    return m;
  endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int PIN_W = $clog2(NPINS)
) (
  input  logic [7:0]       idx,
  output tgt_e             tgt,
  output logic             hi,
  output logic [PIN_W-1:0] pin
);

  localparam logic [8:0] TBL_SPAN = 9'(2 * NPINS);

  logic [7:0] off;

  always_comb begin
    off = idx - IDX_TBL;
    tgt = TGT_NONE;
    hi  = 1'b0;
    pin = '0;
    if (idx == IDX_ID) begin
      tgt = TGT_ID;
    end else if (idx == IDX_VER) begin
      tgt = TGT_VER;
    end else if (idx == IDX_ARB) begin
      tgt = TGT_ARB;
    end else if (idx >= IDX_TBL && {1'b0, off} < TBL_SPAN) begin
      tgt = TGT_ENT;
      hi  = off[0];
      pin = off[PIN_W:1];
    end
  end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_we,
  input  logic [PIN_W-1:0] sw_pin,
  input  logic             sw_hi,
  input  logic [BUS_W-1:0] sw_data,
  input  logic             sts_we,
  input  logic [PIN_W-1:0] sts_pin,
  input  logic             sts_rirr,
  input  logic             sts_dlvs,
  input  logic [PIN_W-1:0] rd_pin,
  output logic [ENT_W-1:0] rd_entry,
  input  logic [PIN_W-1:0] dlv_pin,
  output logic [ENT_W-1:0] dlv_entry,
  output logic             upd_valid,
  output logic [PIN_W-1:0] upd_pin
);

  logic [ENT_W-1:0] ent_q [NPINS];
  logic [NPINS-1:0] rirr_q;
  logic [NPINS-1:0] dlvs_q;
  logic [ENT_W-1:0] view  [NPINS];

  // Software-owned bits: each half is written whole, status positions are
  // overridden on every read by the separately held flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPINS; i++) ent_q[i] <= ENT_RESET;
    end else if (sw_we) begin
      if (sw_hi) ent_q[sw_pin][ENT_W-1:BUS_W] <= sw_data;
      else       ent_q[sw_pin][BUS_W-1:0]     <= sw_data;
    end
  end

  // Hardware-owned status flags, written only from the delivery side.
  always_ff @(posedge clk) begin
    if (rst) begin
      rirr_q <= '0;
      dlvs_q <= '0;
    end else if (sts_we) begin
      rirr_q[sts_pin] <= sts_rirr;
      dlvs_q[sts_pin] <= sts_dlvs;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_view
    assign view[g] = merge_status(ent_q[g], rirr_q[g], dlvs_q[g]);
  end

  assign rd_entry = view[rd_pin];

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_entry <= '0;
      upd_valid <= 1'b0;
      upd_pin   <= '0;
    end else begin
      dlv_entry <= view[dlv_pin];
      upd_valid <= sw_we;
      upd_pin   <= sw_we ? sw_pin : '0;
    end
  end

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sts_we |=> ($stable(rirr_q) && $stable(dlvs_q))); // R7

  AST_NOTICE_PIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |-> (upd_pin == '0)); // R10

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int ID_W   = 8,
  parameter int PIN_W  = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              bus_rvalid,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              sts_we,
  input  logic [PIN_W-1:0]  sts_pin,
  input  logic              sts_rirr,
  input  logic              sts_dlvs,
  input  logic [PIN_W-1:0]  dlv_pin,
  output logic [ENT_W-1:0]  dlv_entry,
  output logic              upd_valid,
  output logic [PIN_W-1:0]  upd_pin
);

  localparam logic [BUS_W-1:0] VER_VAL =
    (BUS_W'(NPINS - 1) << VER_MAX_LSB) | BUS_W'(VER_CODE);
  localparam logic [7:0] TBL_END = 8'(16 + 2 * NPINS);

  logic [BUS_W-1:0] sel_q;
  logic [ID_W-1:0]  id_q;

  logic             rd_req, access_ok, at_sel, at_win, sel_wr, win_wr, sw_we;
  tgt_e             tgt;
  logic             dec_hi;
  logic [PIN_W-1:0] dec_pin;
  logic [ENT_W-1:0] rd_entry;
  logic [BUS_W-1:0] id_word, rd_val;

  assign at_sel    = (bus_addr == ADDR_W'(OFF_SEL));
  assign at_win    = (bus_addr == ADDR_W'(OFF_WIN));
  assign access_ok = bus_valid && (bus_size == SIZE_WORD) && (at_sel || at_win);
  assign rd_req    = bus_valid && !bus_write;
  assign sel_wr    = access_ok && bus_write && at_sel;
  assign win_wr    = access_ok && bus_write && at_win;
  assign sw_we     = win_wr && (tgt == TGT_ENT);
  assign id_word   = {id_q, {(BUS_W - ID_W){1'b0}}};

  irq_route_decode #(.NPINS(NPINS), .PIN_W(PIN_W)) u_dec (
    .idx (sel_q[7:0]),
    .tgt (tgt),
    .hi  (dec_hi),
    .pin (dec_pin)
  );

  irq_route_table #(.NPINS(NPINS), .PIN_W(PIN_W)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_pin    (dec_pin),
    .sw_hi     (dec_hi),
    .sw_data   (bus_wdata),
    .sts_we    (sts_we),
    .sts_pin   (sts_pin),
    .sts_rirr  (sts_rirr),
    .sts_dlvs  (sts_dlvs),
    .rd_pin    (dec_pin),
    .rd_entry  (rd_entry),
    .dlv_pin   (dlv_pin),
    .dlv_entry (dlv_entry),
    .upd_valid (upd_valid),
    .upd_pin   (upd_pin)
  );

  always_comb begin
    rd_val = '0;
    if (access_ok && rd_req) begin
      if (at_sel) begin
        rd_val = sel_q;
      end else begin
        case (tgt)
          TGT_ID, TGT_ARB: rd_val = id_word;
          TGT_VER:         rd_val = VER_VAL;
          TGT_ENT:         rd_val = dec_hi ? rd_entry[ENT_W-1:BUS_W]
                                           : rd_entry[BUS_W-1:0];
          default:         rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      id_q       <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata;
      if (win_wr && tgt == TGT_ID) id_q <= bus_wdata[BUS_W-1:BUS_W-ID_W];
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_val;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid); // R9

  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!bus_rvalid && bus_rdata == '0)); // R9

  AST_BAD_SIZE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_size != SIZE_WORD) |=> (bus_rdata == '0)); // R1

  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_size == SIZE_WORD && at_win && sel_q[7:0] == IDX_VER)
      |=> (bus_rdata == VER_VAL)); // R4

  AST_ID_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bus_size == SIZE_WORD && at_win &&
     (sel_q[7:0] == IDX_ID || sel_q[7:0] == IDX_ARB))
      |=> (bus_rdata[ID_LSB-1:0] == '0)); // R3

  AST_NOTICE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_size == SIZE_WORD && at_win &&
     sel_q[7:0] >= IDX_TBL && sel_q[7:0] < TBL_END) |=> upd_valid); // R10

endmodule

// File: tb/tb_irq_route_regs.sv
module tb_irq_route_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        sts_we = 1'b0, sts_rirr = 1'b0, sts_dlvs = 1'b0;
  logic [4:0]  sts_pin = '0, dlv_pin = '0;
  logic [63:0] dlv_entry;
  logic        upd_valid;
  logic [4:0]  upd_pin;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_route_regs dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .sts_we(sts_we),
    .sts_pin(sts_pin), .sts_rirr(sts_rirr), .sts_dlvs(sts_dlvs),
    .dlv_pin(dlv_pin), .dlv_entry(dlv_entry), .upd_valid(upd_valid),
    .upd_pin(upd_pin)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0, seen_edge = 0;
  string cur_tag = "R8";

  // behavioural reference state
  logic [63:0] m_ent [NPINS];
  bit          m_rirr [NPINS];
  bit          m_dlvs [NPINS];
  logic [31:0] m_sel;
  logic [7:0]  m_id;
  bit          e_rvalid, e_upd, e_rst;
  logic [31:0] e_rdata;
  logic [63:0] e_dlv;
  logic [4:0]  e_updpin;
  string       e_tag;

  function automatic logic [63:0] m_entry(int p);
    logic [63:0] v = m_ent[p];
    v[14] = m_rirr[p];
    v[12] = m_dlvs[p];
    return v;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] r);
    logic [63:0] e;
    if (r == 8'h00 || r == 8'h02) return {m_id, 24'h0};
    if (r == 8'h01) return 32'h001F_0011;
    if (r >= 8'h10 && r < 8'h50) begin
      e = m_entry((int'(r) - 16) / 2);
      return ((int'(r) - 16) % 2 == 1) ? e[63:32] : e[31:0];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    bit ok;
    int r, p;
    seen_edge = 1;
    if (rst) begin
      for (int i = 0; i < NPINS; i++) begin
        m_ent[i] = 64'h0001_0000_0001_0000;
        m_rirr[i] = 0;
        m_dlvs[i] = 0;
      end
      m_sel = 0; m_id = 0;
      e_rvalid = 0; e_rdata = 0; e_dlv = 0; e_upd = 0; e_updpin = 0;
      e_rst = 1; e_tag = "R8";
    end else begin
      e_rst = 0;
      e_tag = cur_tag;
      e_dlv = m_entry(int'(dlv_pin));
      ok = bus_valid && bus_size == 2'd2 && (bus_addr == 8'h00 || bus_addr == 8'h10);
      e_rvalid = bus_valid && !bus_write;
      e_rdata = 0;
      if (e_rvalid && ok) e_rdata = (bus_addr == 8'h00) ? m_sel : m_read(m_sel[7:0]);
      e_upd = 0; e_updpin = 0;
      if (bus_valid && bus_write && ok) begin
        if (bus_addr == 8'h00) m_sel = bus_wdata;
        else begin
          r = int'(m_sel[7:0]);
          if (r == 0) m_id = bus_wdata[31:24];
          else if (r >= 16 && r < 80) begin
            p = (r - 16) / 2;
            if ((r - 16) % 2 == 1) m_ent[p][63:32] = bus_wdata;
            else m_ent[p][31:0] = bus_wdata;
            e_upd = 1; e_updpin = 5'(p);
          end
        end
      end
      if (sts_we) begin
        m_rirr[sts_pin] = sts_rirr;
        m_dlvs[sts_pin] = sts_dlvs;
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (seen_edge && !done) begin
      chk(e_rst ? "R8" : "R9", "rvalid", 64'(bus_rvalid), 64'(e_rvalid));
      chk(e_rst ? "R8" : e_tag, "rdata", 64'(bus_rdata), 64'(e_rdata));
      chk(e_rst ? "R8" : "R11", "dlv_entry", dlv_entry, e_dlv);
      chk(e_rst ? "R8" : "R10", "upd_valid", 64'(upd_valid), 64'(e_upd));
      chk(e_rst ? "R8" : "R10", "upd_pin", 64'(upd_pin), 64'(e_updpin));
    end
  end

  task automatic op(bit w, logic [7:0] a, logic [1:0] s, logic [31:0] d, string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_size = s; bus_wdata = d;
    sts_we = 0; cur_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 0; bus_write = 0; sts_we = 0;
  endtask

  task automatic stat(logic [4:0] p, bit r, bit d);
    @(negedge clk);
    bus_valid = 0; sts_we = 1; sts_pin = p; sts_rirr = r; sts_dlvs = d;
  endtask

  task automatic wsel(logic [31:0] v, string tag);
    op(1, 8'h00, 2'd2, v, tag);
  endtask

  task automatic rwin(string tag);
    op(0, 8'h10, 2'd2, 32'h0, tag);
  endtask

  task automatic wwin(logic [31:0] v, string tag);
    op(1, 8'h10, 2'd2, v, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    dlv_pin = 5'd3;
    // reset contents and index mapping
    op(0, 8'h00, 2'd2, 0, "R8");
    wsel(32'h10, "R5"); rwin("R8");
    wsel(32'h11, "R5"); rwin("R8");
    // identifier and arbitration
    wsel(32'h0, "R3"); wwin(32'hFFFF_FFFF, "R3"); rwin("R3");
    op(0, 8'h00, 2'd2, 0, "R2");
    wsel(32'h2, "R3"); rwin("R3"); wwin(32'h1234_5678, "R3"); rwin("R3");
    wsel(32'h0, "R3"); rwin("R3");
    // version
    wsel(32'h1, "R4"); rwin("R4"); wwin(32'h0, "R4"); rwin("R4");
    // unknown targets and index high bits
    wsel(32'h5, "R2"); wwin(32'hDEAD, "R2"); rwin("R2");
    wsel(32'h50, "R2"); wwin(32'hBEEF, "R2"); rwin("R2");
    wsel(32'h0000_0117, "R2"); rwin("R2");
    // half writes and protected status bits on pin 3
    wsel(32'h16, "R6"); wwin(32'hFFFF_FFFF, "R7"); rwin("R7");
    wsel(32'h17, "R6"); rwin("R6"); wwin(32'hAB00_0000, "R6"); rwin("R6");
    wsel(32'h16, "R6"); rwin("R6");
    stat(5'd3, 1, 1); rwin("R7"); wwin(32'h0, "R7"); rwin("R7");
    stat(5'd3, 0, 1); rwin("R7");
    // dropped accesses
    op(1, 8'h10, 2'd1, 32'h5555_5555, "R1"); rwin("R1");
    op(1, 8'h10, 2'd3, 32'h5555_5555, "R1"); rwin("R1");
    op(0, 8'h04, 2'd2, 0, "R1");
    op(0, 8'h10, 2'd3, 0, "R1");
    op(1, 8'h00, 2'd0, 32'h77, "R1"); op(0, 8'h00, 2'd2, 0, "R1");
    op(1, 8'h14, 2'd2, 32'h77, "R1"); op(0, 8'h00, 2'd2, 0, "R1");
    idle();
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      dlv_pin  = 5'($urandom % NPINS);
      sts_we   = ($urandom % 4) == 0;
      sts_pin  = 5'($urandom % NPINS);
      sts_rirr = 1'($urandom);
      sts_dlvs = 1'($urandom);
      bus_valid = 1; bus_size = 2'd2; bus_wdata = $urandom;
      case ($urandom % 8)
        0: begin bus_valid = 0; bus_write = 0; cur_tag = "R9"; end
        1: begin
          bus_write = 1; bus_addr = 8'h00; cur_tag = "R2";
          case ($urandom % 8)
            0: bus_wdata = 32'h0;
            1: bus_wdata = 32'h1;
            2: bus_wdata = 32'h2;
            3: bus_wdata = 32'h5;
            4: bus_wdata = 32'h50;
            default: bus_wdata = 32'h10 + ($urandom % 64);
          endcase
        end
        2, 3: begin bus_write = 1; bus_addr = 8'h10; cur_tag = "R6"; end
        4, 5: begin bus_write = 0; bus_addr = 8'h10; cur_tag = "R5"; end
        6: begin bus_write = 0; bus_addr = 8'h00; cur_tag = "R2"; end
        default: begin
          bus_write = 1'($urandom); bus_addr = 8'($urandom);
          bus_size = 2'($urandom); cur_tag = "R1";
          if (bus_size == 2'd2 && (bus_addr == 8'h00 || bus_addr == 8'h10))
            bus_size = 2'd1;
        end
      endcase
    end
    idle(); idle(); idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule